// File: doc/BRIEF.md
# Single-Wire Pulse-Width Byte Transmitter

This block sends bytes over an open-drain single-wire line. Each bit occupies a slot of fixed length. The slot opens with the line pulled low, and the bit value is carried only by how long the line stays low. A short low pulse is a one and a long low pulse is a zero. For the rest of the slot the line is released and the pull-up takes it high. The receiver measures pulse widths, so once a slot has begun its timing is never stretched. All timing is counted in ticks of a free-running 1 µs enable strobe.

A byte is offered through a valid/ready handshake. After a byte is accepted, the block waits for the next tick and then sends eight back-to-back slots, least-significant bit first. `busy` is high from acceptance until the high phase of the last slot ends. At that point `done` pulses for one clock and the block can take a new byte. The block never drives the line high. `line_low` enables an external open-drain pull-down. Break pulses, read turnaround and retry are handled elsewhere.

Top module: `pwbit_tx`

## Requirements
- R1: After reset and whenever `busy` is low, `line_low` is 0, `done` is 0 and `in_ready` is 1; ticks arriving while idle leave the line released.
- R2: A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 for as long as `busy` is 1, so a byte offered during a transfer is held off and does not alter the byte being sent.
- R3: Every bit slot starts with `line_low` at 1 and lasts exactly `SLOT_TICKS` ticks. The next slot begins low in the clock right after the previous slot ends, with no gap.
- R4: A bit of value 1 holds `line_low` at 1 for exactly `ONE_LOW_TICKS` ticks, and the line is then released for the rest of the slot.
- R5: A bit of value 0 holds `line_low` at 1 for exactly `ZERO_LOW_TICKS` ticks, and the line is then released for the rest of the slot.
- R6: A byte is sent as `DATA_W` slots with bit 0 first and bit `DATA_W-1` last.
- R7: The first slot starts in the clock after the first tick that follows acceptance. The line therefore goes low between 1 and T clocks after acceptance, where T is the tick spacing. `line_low` changes only in the clock after a tick.
- R8: `busy` rises in the clock after acceptance and falls exactly when the last slot ends. `done` is 1 for exactly that one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-clock enable strobe every microsecond |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block can accept a byte |
| in_data | input | DATA_W | Byte to send, bit 0 first |
| line_low | output | 1 | 1 = pull the line low, 0 = release it |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock pulse when the last slot ends |

## Verification
The case hardest to reach from the ports is a byte offered back to back: `in_valid` is held high with a new byte through a whole transfer and is accepted on the very edge after `done`. The bench holds valid high with a second byte while the first is on the wire. It checks that `in_ready` stays low and that the first byte's pulses decode unchanged. It then checks that the second byte is taken right after the end pulse. The main sweep sends all 256 byte values with a varying idle gap, so the tick phase at acceptance takes every value. For each slot the bench measures the low and high lengths in clocks against tick counts times the tick spacing.

// File: rtl/pwbit_pkg.sv
// Package: shared types for the pulse-width transmitter.
// Assumes nothing beyond IEEE 1800-2017.
package pwbit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a byte
        ST_ARM  = 2'd1,   // byte held, waiting for a tick to align the first slot
        ST_SLOT = 2'd2    // bit slots on the wire
    } tx_state_t;
endpackage

// File: rtl/pwbit_slot_timer.sv
// Module: pwbit_slot_timer
// Counts ticks inside one bit slot. It reports the low phase, whose length
// depends on the current bit, and the tick that closes the slot. The counter
// wraps to 0 at the end of a slot, so back-to-back slots need no restart.
// Assumes: clear is held for as long as no slot is running; tick_en lasts one clock.
module pwbit_slot_timer #(
    parameter int SLOT_TICKS     = 190,
    parameter int ONE_LOW_TICKS  = 20,
    parameter int ZERO_LOW_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick_en,
    input  logic bit_val,
    output logic low_phase,
    output logic slot_last
);
    localparam int CNT_W = (SLOT_TICKS > 1) ? $clog2(SLOT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(SLOT_TICKS - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(ONE_LOW_TICKS);
    localparam logic [CNT_W-1:0] ZERO_C = CNT_W'(ZERO_LOW_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] low_len;

    // Tick counter within the slot; wraps at the slot boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (run && tick_en) begin
            cnt_q <= (cnt_q == LAST_C) ? '0 : cnt_q + 1'b1;
        end
    end

    // Pick the low length for the bit being sent and decode the two phases.
    always_comb begin
        low_len   = bit_val ? ONE_C : ZERO_C;
        low_phase = run && (cnt_q < low_len);
        slot_last = run && tick_en && (cnt_q == LAST_C);
    end
endmodule

// File: rtl/pwbit_shifter.sv
// Module: pwbit_shifter
// Holds the byte being sent and presents the current bit, least significant
// first. It also flags the final bit of the byte.
// Assumes: load and advance are never asserted in the same clock.
module pwbit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] load_data,
    output logic              cur_bit,
    output logic              last_bit
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    // Shift register: load a new byte, or move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load) begin
            sh_q <= load_data;
        end else if (advance) begin
            sh_q <= sh_q >> 1;
        end
    end

    // Bit index: counts the slots already finished within the byte.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Present the current bit and the end-of-byte flag.
    always_comb begin
        cur_bit  = sh_q[0];
        last_bit = (idx_q == LAST_IDX);
    end
endmodule

// File: rtl/pwbit_ctrl.sv
// Module: pwbit_ctrl
// Sequences one byte: accept, align to a tick, run the slots, then report the end.
// Assumes: slot_last comes from the slot timer and lasts one clock.
module pwbit_ctrl
    import pwbit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic in_valid,
    input  logic slot_last,
    input  logic last_bit,
    output logic in_ready,
    output logic load,
    output logic advance,
    output logic timer_clear,
    output logic slot_run,
    output logic busy,
    output logic done
);
    tx_state_t state_q, state_d;
    logic      done_q;

    // Next-state logic and per-state strobes.
    always_comb begin
        state_d     = state_q;
        in_ready    = (state_q == ST_IDLE);
        load        = 1'b0;
        advance     = 1'b0;
        timer_clear = (state_q != ST_SLOT);
        slot_run    = (state_q == ST_SLOT);
        case (state_q)
            ST_IDLE: begin
                if (in_valid) begin
                    load    = 1'b1;
                    state_d = ST_ARM;
                end
            end
            ST_ARM: begin
                if (tick_en) state_d = ST_SLOT;
            end
            ST_SLOT: begin
                if (slot_last) begin
                    if (last_bit) state_d = ST_IDLE;
                    else          advance = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // End pulse: set for the one clock after the last slot closes.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_SLOT) && slot_last && last_bit;
    end

    // Status outputs.
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = done_q;
    end
endmodule

// File: rtl/pwbit_tx.sv
// Module: pwbit_tx (top)
// Open-drain single-wire transmitter with pulse-width encoded bits in fixed slots.
// Assumes: tick_en is a one-clock strobe every microsecond, and
// 0 < ONE_LOW_TICKS, ZERO_LOW_TICKS < SLOT_TICKS. The line is only ever pulled
// low or released.
module pwbit_tx #(
    parameter int DATA_W         = 8,
    parameter int SLOT_TICKS     = 190,
    parameter int ONE_LOW_TICKS  = 20,
    parameter int ZERO_LOW_TICKS = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              line_low,
    output logic              busy,
    output logic              done
);
    logic load, advance, timer_clear, slot_run;
    logic cur_bit, last_bit, low_phase, slot_last;

    pwbit_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .in_valid    (in_valid),
        .slot_last   (slot_last),
        .last_bit    (last_bit),
        .in_ready    (in_ready),
        .load        (load),
        .advance     (advance),
        .timer_clear (timer_clear),
        .slot_run    (slot_run),
        .busy        (busy),
        .done        (done)
    );

    pwbit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .load_data (in_data),
        .cur_bit   (cur_bit),
        .last_bit  (last_bit)
    );

    pwbit_slot_timer #(
        .SLOT_TICKS     (SLOT_TICKS),
        .ONE_LOW_TICKS  (ONE_LOW_TICKS),
        .ZERO_LOW_TICKS (ZERO_LOW_TICKS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (timer_clear),
        .run       (slot_run),
        .tick_en   (tick_en),
        .bit_val   (cur_bit),
        .low_phase (low_phase),
        .slot_last (slot_last)
    );

    // The line is pulled low only during the low phase of a running slot.
    always_comb line_low = low_phase;
endmodule

// File: rtl/pwbit_tx_chk.sv
// Module: pwbit_tx_chk
// Port-level protocol checks for pwbit_tx, attached with bind.
module pwbit_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick_en,
    input logic in_valid,
    input logic in_ready,
    input logic line_low,
    input logic busy,
    input logic done
);
    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_low && in_ready));
    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !in_ready);
    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);
    // R7
    edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_low) |-> $past(tick_en));
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R3
    arm_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !line_low);
endmodule

bind pwbit_tx pwbit_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .line_low (line_low),
    .busy     (busy),
    .done     (done)
);

// File: tb/pwbit_tx_bench.sv
module pwbit_tx_bench;
    localparam int DW   = 8;
    localparam int SLOT = 8;
    localparam int ONE  = 2;
    localparam int ZERO = 5;
    localparam int T    = 3;       // clocks per tick
    localparam int WD_LIMIT = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, line_low, busy, done;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_div = 0;

    pwbit_tx #(.DATA_W(DW), .SLOT_TICKS(SLOT), .ONE_LOW_TICKS(ONE),
               .ZERO_LOW_TICKS(ZERO)) u_pwbit_tx (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .line_low(line_low),
        .busy(busy), .done(done));

    always #5 clk = ~clk;

    // Tick strobe, one clock in every T, changed away from the active edge.
    always @(negedge clk) begin
        tick_div = (tick_div == T - 1) ? 0 : tick_div + 1;
        tick_en <= (tick_div == 0);
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offer a byte and wait until it is accepted; valid drops afterwards.
    task automatic offer(input logic [DW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_data = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(busy && !in_ready, "R2 accept raises busy, drops ready", {busy, in_ready}, 2'b10);
    endtask

    // Measure one byte on the line, starting at the first negedge after acceptance.
    task automatic receive(input logic [DW-1:0] exp, input bit check_ready);
        int wait_n = 0;
        logic [DW-1:0] got = '0;
        while (!line_low) begin
            wait_n++;
            @(negedge clk);
        end
        chk(wait_n >= 1 && wait_n <= T, "R7 first slot on first tick", wait_n, T);
        for (int i = 0; i < DW; i++) begin
            int lowc = 0;
            int highc = 0;
            while (line_low) begin
                lowc++;
                if (check_ready && in_ready) chk(1'b0, "R2 ready low while busy", 1, 0);
                @(negedge clk);
            end
            while (!line_low && busy) begin
                highc++;
                @(negedge clk);
            end
            if (lowc == ONE * T) got[i] = 1'b1;
            else if (lowc == ZERO * T) got[i] = 1'b0;
            else chk(1'b0, exp[i] ? "R4 one low length" : "R5 zero low length",
                     lowc, (exp[i] ? ONE : ZERO) * T);
            if (exp[i]) chk(lowc == ONE * T, "R4 one low length", lowc, ONE * T);
            else        chk(lowc == ZERO * T, "R5 zero low length", lowc, ZERO * T);
            chk(lowc + highc == SLOT * T, "R3 slot length", lowc + highc, SLOT * T);
            if (i < DW - 1) chk(busy === 1'b1, "R8 busy through slots", busy, 1);
        end
        chk(got == exp, "R6 decoded byte, LSB first", got, exp);
        chk(!busy && done, "R8 busy falls with done", {busy, done}, 2'b01);
        chk(!line_low, "R1 line released at end", line_low, 0);
        @(negedge clk);
        chk(!done, "R8 done one clock", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state.
        chk(!line_low && !busy && !done && in_ready, "R1 reset state",
            {line_low, busy, done, in_ready}, 4'b0001);
        rst_n = 1'b1;
        // R1: ticks while idle leave the line released.
        for (int k = 0; k < 4 * T; k++) begin
            @(negedge clk);
            if (line_low || busy || done) chk(1'b0, "R1 idle ticks ignored", line_low, 0);
        end
        chk(!line_low && in_ready, "R1 idle after ticks", line_low, 0);

        // Full sweep of byte values with varying idle gaps.
        for (int b = 0; b < 256; b++) begin
            offer(b[DW-1:0]);
            receive(b[DW-1:0], 1'b0);
            for (int g = 0; g < (b % 4); g++) begin
                @(negedge clk);
                if (line_low) chk(1'b0, "R1 line released in gap", line_low, 0);
            end
        end

        // R2: byte held off while busy, then taken right after done.
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'hA5;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_data = 8'h3C;                 // second byte offered during the transfer
        chk(!in_ready && busy, "R2 new byte held off", in_ready, 0);
        receive(8'hA5, 1'b1);
        // receive ended one clock after done; valid was high with ready, so
        // the second byte is already accepted.
        chk(busy && !in_ready, "R2 held byte accepted after done", {busy, in_ready}, 2'b10);
        in_valid = 1'b0;
        receive(8'h3C, 1'b1);

        // R6: patterns with a single one and a single zero.
        offer(8'h80); receive(8'h80, 1'b0);
        offer(8'hFE); receive(8'hFE, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule